// File: doc/BRIEF.md
# Byte-Interleaved Unaligned Multi-Byte RAM

This block is the tightly coupled memory of a fast 8-bit processor core. Storage is split over four byte-wide banks, with byte address A held in bank A mod 4. Every bank computes its own row, so a run of up to four consecutive bytes can be read or written in one access whatever its alignment. The processor uses this to fetch an opcode and its operands together through a read-only fetch port. At the same time, a second port serves data loads and stores of one to four bytes.

The RAM clock runs at twice the processor clock. RAM cycles alternate between a processor slot and a DMA slot, and `cpu_slot_o` marks the processor slot. In a DMA slot, both ports of every bank are bonded into one path, which moves an aligned group of eight bytes. Raising `suspend_i` hands the processor slot to DMA as well, so DMA can run on every RAM cycle. Read data for a processor port is registered at the end of the DMA half. It therefore appears one processor cycle after the address was presented and holds until that port's next read.

Top module: `ilv_ram`

## Requirements
- R1: A byte written at address A through any port reads back at address A through any port. Byte A is stored in bank A mod 4.
- R2: A fetch request at any address A returns bytes A, A+1, A+2 and A+3 on `ifu_rdata_o`. Lane j is bits [8j+7:8j], lane 0 holds byte A, and addresses wrap modulo the memory size.
- R3: A data read returns `dat_len_i`+1 bytes (`dat_len_i` = 0..3) starting at any address A, with lane 0 holding byte A and wraparound as in R2. Lanes at or beyond the byte count read as zero.
- R4: A data write stores lanes 0..`dat_len_i` of `dat_wdata_i` at A.. A+`dat_len_i`. No other byte changes.
- R5: A processor read presented in a processor slot appears on its output after the following DMA slot's edge. The output holds its value until the next accepted read on that port, and a write leaves `dat_rdata_o` unchanged.
- R6: After reset, `cpu_slot_o` is 1. It then toggles on every RAM clock edge.
- R7: `dma_gnt_o` equals `dma_req_i` during a DMA slot and is 0 in a processor slot unless suspended. Processor accesses never wait for DMA.
- R8: A granted DMA access covers bytes 8·`dma_addr_i`+i for lane i = 0..7. Writes store only the lanes with `dma_be_i[i]`=1. A granted read raises `dma_rvalid_o` in the next RAM cycle, with the eight bytes on `dma_rdata_o`.
- R9: When `suspend_i` is 1 in a processor slot, DMA is granted that slot. Processor requests in that slot have no effect on memory or outputs.
- R10: When the fetch port and a data write touch the same byte in one slot, the fetch returns the value from before the write.
- R11: During and straight after reset, `ifu_rdata_o`, `dat_rdata_o` and `dma_rvalid_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | RAM clock, twice the processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| suspend_i | input | 1 | Give processor slots to DMA |
| cpu_slot_o | output | 1 | The next edge is a processor slot |
| ifu_req_i | input | 1 | Fetch read request |
| ifu_addr_i | input | ADDR_W | Fetch start byte address |
| ifu_rdata_o | output | 32 | Four fetched bytes, lane 0 = start byte |
| dat_req_i | input | 1 | Data access request |
| dat_we_i | input | 1 | 1 = write, 0 = read |
| dat_addr_i | input | ADDR_W | Data start byte address |
| dat_len_i | input | 2 | Byte count minus one |
| dat_wdata_i | input | 32 | Write bytes, lane 0 = start byte |
| dat_rdata_o | output | 32 | Read bytes, unused lanes zero |
| dma_req_i | input | 1 | DMA access request |
| dma_we_i | input | 1 | 1 = write, 0 = read |
| dma_addr_i | input | ADDR_W-3 | Eight-byte group index |
| dma_be_i | input | 8 | Per-lane write enable |
| dma_wdata_i | input | 64 | DMA write bytes |
| dma_gnt_o | output | 1 | DMA request taken at this edge |
| dma_rvalid_o | output | 1 | DMA read data valid |
| dma_rdata_o | output | 64 | DMA read bytes |

## Verification
The hardest case to reach from the ports is a processor slot that carries several kinds of traffic at once. In that slot, a fetch and a data write hit the same bytes while a DMA request waits and `suspend_i` flips. The bench therefore schedules its stimulus per processor cycle, with one DMA request per half. It places directed same-address fetch/write pairs, suspended slots that carry processor writes, and spans that wrap past the top address. Random mixes then let DMA and processor traffic overlap on a mirror model that applies the accesses in slot order.

// File: rtl/ilv_ram_pkg.sv
package ilv_ram_pkg;
  localparam int NBANK  = 4;
  localparam int LANE_W = 8;
  localparam int OFF_W  = $clog2(NBANK);
  localparam int WORD_W = NBANK * LANE_W;
  localparam int DMA_W  = 2 * WORD_W;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [OFF_W-1:0]  off_t;
endpackage

// File: rtl/ilv_ram_bank.sv
module ilv_ram_bank
  import ilv_ram_pkg::*;
#(
  parameter int ROW_W = 10
) (
  input  logic             clk_i,
  input  logic             a_en_i,
  input  logic             a_we_i,
  input  logic [ROW_W-1:0] a_row_i,
  input  lane_t            a_wd_i,
  output lane_t            a_rd_o,
  input  logic             b_en_i,
  input  logic             b_we_i,
  input  logic [ROW_W-1:0] b_row_i,
  input  lane_t            b_wd_i,
  output lane_t            b_rd_o
);
  localparam int DEPTH = 1 << ROW_W;

  lane_t mem_q [DEPTH];

  // read-first on both ports
  always_ff @(posedge clk_i) begin
    if (a_en_i) begin
      if (a_we_i) mem_q[a_row_i] <= a_wd_i;
      a_rd_o <= mem_q[a_row_i];
    end
    if (b_en_i) begin
      if (b_we_i) mem_q[b_row_i] <= b_wd_i;
      b_rd_o <= mem_q[b_row_i];
    end
  end
endmodule

// File: rtl/ilv_span_map.sv
module ilv_span_map
  import ilv_ram_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int ROW_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  off_t                         len_i,
  output logic [NBANK-1:0][ROW_W-1:0]  row_o,
  output logic [NBANK-1:0]             en_o,
  output off_t [NBANK-1:0]             lane_o
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    off_t k;
    // byte offset of this bank inside the span
    assign k         = OFF_W'(b) - addr_i[OFF_W-1:0];
    assign lane_o[b] = k;
    assign en_o[b]   = (k <= len_i);
    // banks below the start offset take the next row
    assign row_o[b]  = addr_i[ADDR_W-1:OFF_W]
                     + ROW_W'(OFF_W'(b) < addr_i[OFF_W-1:0]);
  end
endmodule

// File: rtl/ilv_lane_rot.sv
module ilv_lane_rot
  import ilv_ram_pkg::*;
(
  input  logic [WORD_W-1:0] bank_i,
  input  off_t              off_i,
  input  off_t              len_i,
  output logic [WORD_W-1:0] lane_o
);
  for (genvar j = 0; j < NBANK; j++) begin : g_lane
    off_t src;
    assign src = off_i + OFF_W'(j);
    assign lane_o[j*LANE_W +: LANE_W] =
      (OFF_W'(j) <= len_i) ? bank_i[{src, 3'b000} +: LANE_W] : '0;
  end
endmodule

// File: rtl/ilv_ram.sv
module ilv_ram
  import ilv_ram_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int ROW_W = ADDR_W - OFF_W,
  localparam int GRP_W = ADDR_W - OFF_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              suspend_i,
  output logic              cpu_slot_o,
  input  logic              ifu_req_i,
  input  logic [ADDR_W-1:0] ifu_addr_i,
  output logic [WORD_W-1:0] ifu_rdata_o,
  input  logic              dat_req_i,
  input  logic              dat_we_i,
  input  logic [ADDR_W-1:0] dat_addr_i,
  input  logic [OFF_W-1:0]  dat_len_i,
  input  logic [WORD_W-1:0] dat_wdata_i,
  output logic [WORD_W-1:0] dat_rdata_o,
  input  logic              dma_req_i,
  input  logic              dma_we_i,
  input  logic [GRP_W-1:0]  dma_addr_i,
  input  logic [2*NBANK-1:0] dma_be_i,
  input  logic [DMA_W-1:0]  dma_wdata_i,
  output logic              dma_gnt_o,
  output logic              dma_rvalid_o,
  output logic [DMA_W-1:0]  dma_rdata_o
);
  logic slot_q;
  logic cpu_go, dma_go;

  assign cpu_go    = slot_q & ~suspend_i;
  assign dma_go    = dma_req_i & (~slot_q | suspend_i);
  assign dma_gnt_o = dma_go;
  assign cpu_slot_o = slot_q;

  logic [NBANK-1:0][ROW_W-1:0] ifu_row, dat_row;
  logic [NBANK-1:0]            ifu_en, dat_en;
  off_t [NBANK-1:0]            ifu_lane, dat_lane;

  ilv_span_map #(.ADDR_W(ADDR_W)) u_ifu_map (
    .addr_i(ifu_addr_i), .len_i(OFF_W'(NBANK-1)),
    .row_o(ifu_row), .en_o(ifu_en), .lane_o(ifu_lane)
  );

  ilv_span_map #(.ADDR_W(ADDR_W)) u_dat_map (
    .addr_i(dat_addr_i), .len_i(dat_len_i),
    .row_o(dat_row), .en_o(dat_en), .lane_o(dat_lane)
  );

  logic [NBANK-1:0] a_en, a_we, b_en, b_we;
  logic [WORD_W-1:0] a_bus, b_bus;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [ROW_W-1:0] a_row, b_row;
    lane_t a_wd, b_wd, dat_wl, a_rd, b_rd;

    assign dat_wl = dat_wdata_i[{dat_lane[b], 3'b000} +: LANE_W];

    // port A: fetch in CPU slots, low half of the DMA group otherwise
    assign a_en[b] = cpu_go ? (ifu_req_i & ifu_en[b]) : dma_go;
    assign a_we[b] = ~cpu_go & dma_go & dma_we_i & dma_be_i[b];
    assign a_row   = cpu_go ? ifu_row[b] : {dma_addr_i, 1'b0};
    assign a_wd    = dma_wdata_i[b*LANE_W +: LANE_W];

    // port B: load/store in CPU slots, high half of the DMA group otherwise
    assign b_en[b] = cpu_go ? (dat_req_i & dat_en[b]) : dma_go;
    assign b_we[b] = cpu_go ? (dat_req_i & dat_we_i & dat_en[b])
                            : (dma_go & dma_we_i & dma_be_i[NBANK+b]);
    assign b_row   = cpu_go ? dat_row[b] : {dma_addr_i, 1'b1};
    assign b_wd    = cpu_go ? dat_wl
                            : dma_wdata_i[(NBANK+b)*LANE_W +: LANE_W];

    ilv_ram_bank #(.ROW_W(ROW_W)) u_bank (
      .clk_i(clk_i),
      .a_en_i(a_en[b]), .a_we_i(a_we[b]), .a_row_i(a_row), .a_wd_i(a_wd), .a_rd_o(a_rd),
      .b_en_i(b_en[b]), .b_we_i(b_we[b]), .b_row_i(b_row), .b_wd_i(b_wd), .b_rd_o(b_rd)
    );

    assign a_bus[b*LANE_W +: LANE_W] = a_rd;
    assign b_bus[b*LANE_W +: LANE_W] = b_rd;
    assign dma_rdata_o[b*LANE_W +: LANE_W]         = a_rd;
    assign dma_rdata_o[(NBANK+b)*LANE_W +: LANE_W] = b_rd;
  end

  logic ifu_took_q, dat_took_q;
  off_t ifu_off_q, dat_off_q, dat_len_q;
  logic [WORD_W-1:0] ifu_rot, dat_rot;

  ilv_lane_rot u_ifu_rot (
    .bank_i(a_bus), .off_i(ifu_off_q), .len_i(OFF_W'(NBANK-1)), .lane_o(ifu_rot)
  );

  ilv_lane_rot u_dat_rot (
    .bank_i(b_bus), .off_i(dat_off_q), .len_i(dat_len_q), .lane_o(dat_rot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q       <= 1'b1;
      ifu_took_q   <= 1'b0;
      dat_took_q   <= 1'b0;
      ifu_off_q    <= '0;
      dat_off_q    <= '0;
      dat_len_q    <= '0;
      ifu_rdata_o  <= '0;
      dat_rdata_o  <= '0;
      dma_rvalid_o <= 1'b0;
    end else begin
      slot_q       <= ~slot_q;
      dma_rvalid_o <= dma_go & ~dma_we_i;
      if (cpu_go) begin
        ifu_took_q <= ifu_req_i;
        dat_took_q <= dat_req_i & ~dat_we_i;
        ifu_off_q  <= ifu_addr_i[OFF_W-1:0];
        dat_off_q  <= dat_addr_i[OFF_W-1:0];
        dat_len_q  <= dat_len_i;
      end else begin
        ifu_took_q <= 1'b0;
        dat_took_q <= 1'b0;
      end
      // capture at the end of the DMA half, before banks are reused
      if (!slot_q && ifu_took_q) ifu_rdata_o <= ifu_rot;
      if (!slot_q && dat_took_q) dat_rdata_o <= dat_rot;
    end
  end

  p_slot_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_slot_o |=> !cpu_slot_o);

  p_span_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_req_i |-> ($countones(dat_en) == int'(dat_len_i) + 1));

  p_suspend_no_store_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && cpu_slot_o && !dma_req_i) |-> (b_we == '0 && a_we == '0));

  p_dma_rvalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_gnt_o && !dma_we_i) |=> dma_rvalid_o);

  p_out_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_slot_o |=> ($stable(ifu_rdata_o) && $stable(dat_rdata_o)));
endmodule

// File: tb/sim_ilv_ram.sv
`timescale 1ns/1ps
module sim_ilv_ram;
  localparam int AW  = 12;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        suspend, cpu_slot;
  logic        ifu_req;  logic [AW-1:0] ifu_addr; logic [31:0] ifu_rdata;
  logic        dat_req, dat_we; logic [AW-1:0] dat_addr; logic [1:0] dat_len;
  logic [31:0] dat_wdata, dat_rdata;
  logic        dma_req, dma_we; logic [AW-4:0] dma_addr; logic [7:0] dma_be;
  logic [63:0] dma_wdata, dma_rdata; logic dma_gnt, dma_rvalid;

  ilv_ram #(.ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .suspend_i(suspend), .cpu_slot_o(cpu_slot),
    .ifu_req_i(ifu_req), .ifu_addr_i(ifu_addr), .ifu_rdata_o(ifu_rdata),
    .dat_req_i(dat_req), .dat_we_i(dat_we), .dat_addr_i(dat_addr), .dat_len_i(dat_len),
    .dat_wdata_i(dat_wdata), .dat_rdata_o(dat_rdata),
    .dma_req_i(dma_req), .dma_we_i(dma_we), .dma_addr_i(dma_addr), .dma_be_i(dma_be),
    .dma_wdata_i(dma_wdata), .dma_gnt_o(dma_gnt), .dma_rvalid_o(dma_rvalid),
    .dma_rdata_o(dma_rdata)
  );

  logic [7:0] m [MSZ];
  int n_chk = 0, n_err = 0;
  logic [31:0] exp_ifu, exp_dat;
  logic        exp_dv;
  logic [63:0] exp_dd;

  // stimulus for one processor cycle
  logic s_sus, s_fr, s_dr, s_dw;
  logic [AW-1:0] s_fa, s_da; logic [1:0] s_dl; logic [31:0] s_dwd;
  logic t_req [2]; logic t_we [2]; logic [AW-4:0] t_adr [2];
  logic [7:0] t_be [2]; logic [63:0] t_wd [2];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rd_n(input logic [AW-1:0] a, input int cnt);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++)
      if (i < cnt) r[8*i +: 8] = m[(int'(a) + i) % MSZ];
    return r;
  endfunction

  task automatic clr();
    s_sus = 0; s_fr = 0; s_dr = 0; s_dw = 0; s_fa = '0; s_da = '0; s_dl = '0; s_dwd = '0;
    for (int s = 0; s < 2; s++) begin
      t_req[s] = 0; t_we[s] = 0; t_adr[s] = '0; t_be[s] = '0; t_wd[s] = '0;
    end
  endtask

  task automatic drive_dma(input int s);
    dma_req = t_req[s]; dma_we = t_we[s]; dma_addr = t_adr[s];
    dma_be = t_be[s]; dma_wdata = t_wd[s];
  endtask

  task automatic dma_model(input int s, input logic granted);
    exp_dv = 0;
    if (granted && t_req[s]) begin
      if (t_we[s]) begin
        for (int i = 0; i < 8; i++)
          if (t_be[s][i]) m[8*int'(t_adr[s]) + i] = t_wd[s][8*i +: 8];
      end else begin
        exp_dv = 1;
        for (int i = 0; i < 8; i++) exp_dd[8*i +: 8] = m[8*int'(t_adr[s]) + i];
      end
    end
  endtask

  task automatic check_outs();
    chk("R8 dma rvalid", {63'd0, dma_rvalid}, {63'd0, exp_dv});
    if (exp_dv) chk("R1/R8 dma read data", dma_rdata, exp_dd);
    chk("R2/R5 fetch data", {32'd0, ifu_rdata}, {32'd0, exp_ifu});
    chk("R3/R5 load data", {32'd0, dat_rdata}, {32'd0, exp_dat});
  endtask

  // entered at the negedge before a processor slot edge, leaves at the next one
  task automatic run_cycle();
    logic [31:0] nifu, ndat;
    chk("R6 processor slot", {63'd0, cpu_slot}, 64'd1);
    check_outs();
    suspend = s_sus; ifu_req = s_fr; ifu_addr = s_fa;
    dat_req = s_dr; dat_we = s_dw; dat_addr = s_da; dat_len = s_dl; dat_wdata = s_dwd;
    drive_dma(0);
    #1;
    chk("R7/R9 grant in processor slot", {63'd0, dma_gnt}, {63'd0, t_req[0] & s_sus});
    nifu = exp_ifu; ndat = exp_dat;
    if (!s_sus) begin
      if (s_fr) nifu = rd_n(s_fa, 4);            // R10: before the write
      if (s_dr && !s_dw) ndat = rd_n(s_da, int'(s_dl) + 1);
      if (s_dr && s_dw)
        for (int i = 0; i <= int'(s_dl); i++) m[(int'(s_da) + i) % MSZ] = s_dwd[8*i +: 8];
    end
    dma_model(0, s_sus);
    @(negedge clk);
    chk("R6 DMA slot", {63'd0, cpu_slot}, 64'd0);
    check_outs();
    ifu_req = 0; dat_req = 0;
    drive_dma(1);
    #1;
    chk("R7 grant in DMA slot", {63'd0, dma_gnt}, {63'd0, t_req[1]});
    dma_model(1, 1'b1);
    exp_ifu = nifu; exp_dat = ndat;
    @(negedge clk);
  endtask

  logic wd_fired = 0;
  initial begin
    repeat (150000) @(posedge clk);
    wd_fired = 1;
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    clr();
    suspend = 0; ifu_req = 0; ifu_addr = '0; dat_req = 0; dat_we = 0; dat_addr = '0;
    dat_len = '0; dat_wdata = '0; drive_dma(0);
    exp_ifu = '0; exp_dat = '0; exp_dv = 0; exp_dd = '0;
    repeat (3) @(negedge clk);
    chk("R11 fetch out in reset", {32'd0, ifu_rdata}, 64'd0);
    chk("R11 load out in reset", {32'd0, dat_rdata}, 64'd0);
    chk("R11 rvalid in reset", {63'd0, dma_rvalid}, 64'd0);
    rst_n = 1;
    chk("R6 slot after reset", {63'd0, cpu_slot}, 64'd1);

    // R9 fill: suspended, DMA writes in both halves
    for (int g = 0; g < MSZ / 8; g += 2) begin
      clr(); s_sus = 1;
      for (int s = 0; s < 2; s++) begin
        t_req[s] = 1; t_we[s] = 1; t_adr[s] = (AW-3)'(g + s); t_be[s] = 8'hFF;
        t_wd[s] = {$urandom(), $urandom()};
      end
      run_cycle();
    end

    // R2 fetch at each alignment and across the top
    for (int a = 0; a < 4; a++) begin clr(); s_fr = 1; s_fa = AW'(16 + a); run_cycle(); end
    clr(); s_fr = 1; s_fa = AW'(MSZ - 2); run_cycle();
    // R3 every length, wrapping start
    for (int l = 0; l < 4; l++) begin
      clr(); s_dr = 1; s_da = AW'(MSZ - 3 + l); s_dl = 2'(l); run_cycle();
    end
    // R4 single-byte store at offset 3, then read the word around it
    clr(); s_dr = 1; s_dw = 1; s_da = AW'(12'h103); s_dl = 0; s_dwd = 32'hAABBCCDD; run_cycle();
    clr(); s_dr = 1; s_da = AW'(12'h100); s_dl = 3; run_cycle();
    clr(); s_dr = 1; s_da = AW'(12'h104); s_dl = 3; run_cycle();
    // R10 fetch and store on the same bytes in one slot
    clr(); s_fr = 1; s_fa = AW'(12'h201); s_dr = 1; s_dw = 1; s_da = AW'(12'h202);
    s_dl = 3; s_dwd = 32'h11223344; run_cycle();
    clr(); s_fr = 1; s_fa = AW'(12'h201); run_cycle();
    // R9 suspended slot ignores processor store and fetch
    clr(); s_sus = 1; s_fr = 1; s_fa = AW'(12'h300); s_dr = 1; s_dw = 1; s_da = AW'(12'h300);
    s_dl = 3; s_dwd = 32'hDEADBEEF; run_cycle();
    clr(); s_dr = 1; s_da = AW'(12'h300); s_dl = 3; run_cycle();
    // R8 partial byte enables, read back through DMA and processor
    clr(); t_req[1] = 1; t_we[1] = 1; t_adr[1] = (AW-3)'(9'h40); t_be[1] = 8'hA5;
    t_wd[1] = 64'h0123456789ABCDEF; run_cycle();
    clr(); t_req[1] = 1; t_adr[1] = (AW-3)'(9'h40); s_fr = 1; s_fa = AW'(12'h203); run_cycle();
    clr(); s_dr = 1; s_da = AW'(12'h206); s_dl = 3; run_cycle();

    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      clr();
      s_sus = ($urandom() % 8) == 0;
      s_fr = $urandom(); s_fa = AW'($urandom());
      s_dr = $urandom(); s_dw = $urandom(); s_da = AW'($urandom());
      s_dl = 2'($urandom()); s_dwd = $urandom();
      for (int s = 0; s < 2; s++) begin
        t_req[s] = $urandom(); t_we[s] = $urandom(); t_adr[s] = (AW-3)'($urandom());
        t_be[s] = 8'($urandom()); t_wd[s] = {$urandom(), $urandom()};
      end
      run_cycle();
    end
    clr(); run_cycle();

    if (!wd_fired) begin
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule